// File: doc/BRIEF.md
# Consecutive-Service System Enable Qualifier

This block drives an active-low system-enable output. The output holds critical actuators off while a processor recovers from reset. The enable stays negated after any reset until the watchdog reports a run of correctly timed services. The default run length is three, and a parameter sets it. Only after that run does the enable go active. A processor that is reset again and again never builds up the run, so it never energizes what the enable guards.

The block takes three inputs, all sampled on the same clock. The first is the watchdog's reset state. The second is a one-cycle strobe for each service that lands in the open window. The third is a power-good flag. Window timing and reset pulse generation stay in the watchdog. Reset state and power loss both force the output negated in the same cycle they are seen, without waiting for a clock edge. At the next edge they also discard any progress toward the run.

Top module: `sys_enable_qual`

## Requirements
- R1: While rst_ni is low, en_no_o is 1 and the service count is zero, so a full run of SVC_NEED services is needed after rst_ni rises.
- R2: In any cycle where wd_rst_i is 1, en_no_o is 1 in that same cycle.
- R3: In any cycle where pwr_good_i is 0, en_no_o is 1 in that same cycle.
- R4: en_no_o goes to 0 after the clock edge that samples the SVC_NEED-th svc_ok_i pulse since the last reset event. Before that edge it stays 1.
- R5: A reset event is a clock edge that samples wd_rst_i=1 or pwr_good_i=0. It clears the service count and the enable state, so SVC_NEED fresh services are needed afterwards.
- R6: An svc_ok_i pulse sampled in the same edge as a reset event is not counted.
- R7: Once en_no_o is 0, it stays 0 until the next reset event, whatever happens on svc_ok_i. The service count saturates at SVC_NEED.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wd_rst_i | input | 1 | Watchdog reset state, 1 while reset is asserted |
| svc_ok_i | input | 1 | One-cycle strobe per in-window service |
| pwr_good_i | input | 1 | Supply above threshold when 1 |
| en_no_o | output | 1 | System enable, active low |

## Verification
The assertions check three things on every cycle. Reset state and power loss must force the enable negated at once. The enable may never be active before a checker-side count of services since the last reset event reaches SVC_NEED. An active enable must persist while no reset event occurs. Other behaviours show up only in the bench's sweep of every four-cycle pattern of service, reset and power-drop inputs, each started from a cleared state. These are: activation on exactly the SVC_NEED-th service, a service being ignored when it coincides with a reset event, and a partial run being discarded.

// File: rtl/sen_pkg.sv
package sen_pkg;
  typedef enum logic {
    EN_ON  = 1'b0,
    EN_OFF = 1'b1
  } en_level_e;
endpackage

// File: rtl/sen_clear_gen.sv
module sen_clear_gen (
  input  logic wd_rst_i,
  input  logic pwr_good_i,
  output logic clear_o
);
  assign clear_o = wd_rst_i | ~pwr_good_i;
endmodule

// File: rtl/sen_svc_counter.sv
module sen_svc_counter #(
  parameter int unsigned SVC_NEED = 3,
  localparam int unsigned CntW    = $clog2(SVC_NEED + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic svc_i,
  output logic reached_o
);
  localparam logic [CntW-1:0] LastCnt = CntW'(SVC_NEED - 1);
  localparam logic [CntW-1:0] SatCnt  = CntW'(SVC_NEED);

  logic [CntW-1:0] cnt_q;

  // pulse on the service that completes the run
  assign reached_o = svc_i & ~clear_i & (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clear_i)                 cnt_q <= '0;
    else if (svc_i && cnt_q < SatCnt) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sen_en_hold.sv
module sen_en_hold (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  output logic active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_o <= 1'b0;
    else if (clear_i) active_o <= 1'b0;
    else if (set_i)   active_o <= 1'b1;
  end
endmodule

// File: rtl/sys_enable_qual.sv
module sys_enable_qual
  import sen_pkg::*;
#(
  parameter int unsigned SVC_NEED = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wd_rst_i,
  input  logic svc_ok_i,
  input  logic pwr_good_i,
  output logic en_no_o
);
  logic clear;
  logic reached;
  logic active;
  en_level_e en_lvl;

  sen_clear_gen i_clear (
    .wd_rst_i  (wd_rst_i),
    .pwr_good_i(pwr_good_i),
    .clear_o   (clear)
  );

  sen_svc_counter #(.SVC_NEED(SVC_NEED)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear),
    .svc_i    (svc_ok_i),
    .reached_o(reached)
  );

  sen_en_hold i_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .set_i   (reached),
    .active_o(active)
  );

  // reset state and power loss override the held state without a clock
  assign en_lvl  = (active && !clear) ? EN_ON : EN_OFF;
  assign en_no_o = en_lvl;
endmodule

// File: rtl/sen_checker.sv
module sen_checker #(
  parameter int unsigned SVC_NEED = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wd_rst_i,
  input logic svc_ok_i,
  input logic pwr_good_i,
  input logic en_no_o
);
  int unsigned seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           seen_q <= 0;
    else if (wd_rst_i || !pwr_good_i)      seen_q <= 0;
    else if (svc_ok_i && seen_q < SVC_NEED) seen_q <= seen_q + 1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_off_R1: assert (en_no_o === 1'b1);
  end

  assert_wd_forces_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_rst_i |-> en_no_o);

  assert_pg_forces_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_good_i |-> en_no_o);

  assert_no_early_enable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q < SVC_NEED) |-> en_no_o);

  assert_enable_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_no_o && !wd_rst_i && pwr_good_i) |=> (en_no_o == (wd_rst_i || !pwr_good_i)));
endmodule

bind sys_enable_qual sen_checker #(.SVC_NEED(SVC_NEED)) i_sen_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wd_rst_i  (wd_rst_i),
  .svc_ok_i  (svc_ok_i),
  .pwr_good_i(pwr_good_i),
  .en_no_o   (en_no_o)
);

// File: tb/test_sys_enable_qual.sv
module test_sys_enable_qual;
  localparam int unsigned SVC_NEED = 3;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned MAX_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wd_rst = 1'b0;
  logic svc_ok = 1'b0;
  logic pwr_good = 1'b1;
  logic en_no;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  // bench model
  int unsigned m_cnt = 0;
  bit m_act = 0;
  bit m_after_clear = 0;

  sys_enable_qual #(.SVC_NEED(SVC_NEED)) i_sys_enable_qual (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wd_rst_i  (wd_rst),
    .svc_ok_i  (svc_ok),
    .pwr_good_i(pwr_good),
    .en_no_o   (en_no)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: en_no_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // op bits: [2] power drop, [1] watchdog reset, [0] service
  task automatic step(input logic [2:0] op);
    string req;
    logic exp;
    @(negedge clk);
    pwr_good = ~op[2];
    wd_rst   = op[1];
    svc_ok   = op[0];
    #1;
    exp = !m_act || op[1] || op[2];
    if (op[1])              req = "R2";
    else if (op[2])         req = "R3";
    else if (m_act)         req = "R7";
    else if (m_after_clear) req = "R5";
    else                    req = "R4";
    check(req, en_no, exp);
    @(posedge clk);
    if (op[1] || op[2]) begin
      m_cnt = 0; m_act = 0; m_after_clear = 1;
    end else if (op[0]) begin
      if (m_cnt < SVC_NEED) m_cnt++;
      if (m_cnt == SVC_NEED) m_act = 1;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles >= MAX_CYCLES) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, MAX_CYCLES);
        finish_run();
      end
    end
  end

  initial begin
    // R1: reset state
    #(CLK_PERIOD*2);
    check("R1", en_no, 1'b1);
    rst_ni = 1'b1;
    m_after_clear = 0;

    // R4: run from reset, then R7 hold with extra services (saturation)
    for (int i = 0; i < SVC_NEED; i++) step(3'b001);
    step(3'b000);
    for (int i = 0; i < 5; i++) step(3'b001);
    step(3'b000);

    // R5: reset event discards progress
    step(3'b010);
    step(3'b001); step(3'b001);
    step(3'b100);
    for (int i = 0; i < SVC_NEED; i++) step(3'b001);
    step(3'b000);

    // R6: service coinciding with reset event not counted
    step(3'b011);
    step(3'b001); step(3'b001);
    @(negedge clk); svc_ok = 0; wd_rst = 0; pwr_good = 1; #1;
    check("R6", en_no, 1'b1);
    step(3'b001);
    step(3'b000);

    // R1: asynchronous reset mid-run clears progress
    step(3'b001); step(3'b001);
    @(negedge clk); rst_ni = 1'b0; svc_ok = 0; #1;
    check("R1", en_no, 1'b1);
    @(negedge clk); rst_ni = 1'b1;
    m_cnt = 0; m_act = 0;
    step(3'b001);
    step(3'b000);

    // exhaustive four-cycle patterns from a cleared state
    for (int s = 0; s < 4096; s++) begin
      step(3'b010);
      for (int k = 0; k < 4; k++) step(3'((s >> (3*k)) & 7));
    end

    finish_run();
  end
endmodule